// File: doc/BRIEF.md
# Dual Serial Gamepad Poller

This block reads two serial game controllers through a shared latch-and-clock interface. A single `start` pulse begins one acquisition. The block raises a strobe so both controllers capture their button states. It then lowers the strobe and issues read clocks, shifting one bit per clock from each controller into that port's result byte. Each port has two data lines, one for a standard pad and one for an expansion pad. The bit stored for a port is the OR of those two lines.

The block does not count read steps. It preloads a single marker bit into the second port's shift register, and the acquisition ends when that marker falls out of the top of the register. With `verify_en` set, the block repeats the acquisition and compares each result with the one before it. It accepts a result only when two consecutive acquisitions agree on both ports. This filters out single corrupted reads on a noisy bus. The number of mismatches is capped. When the cap is reached, the block reports the latest result with an error flag. The byte outputs and the flag are updated only in the cycle in which `done` pulses.

Top module: `pad_poller`

## Requirements
- R1: After reset, `buttons1`, `buttons2`, `err`, `done`, `strobe_out` and `read_clk_out` are all 0.
- R2: Each acquisition starts with `strobe_out` high for exactly `STROBE_CYC` clock cycles.
- R3: Each acquisition issues exactly eight `read_clk_out` pulses, each high for `RCLK_HALF` cycles. No pulse is ever high while `strobe_out` is high. Data are sampled only after the strobe has fallen.
- R4: The first bit a controller presents after the strobe falls is stored in bit 7 of the result, and the eighth bit is stored in bit 0. So A, B, Select, Start, Up, Down, Left and Right occupy bit 7 down to bit 0. A pressed button reads as 1.
- R5: For each port, the captured bit is 1 when data line 0 (standard pad) or data line 1 (expansion pad) is high, and 0 when both are low.
- R6: Both ports are sampled on the same read step, and each port's byte depends only on that port's data lines.
- R7: With `verify_en` low at `start`, exactly one acquisition runs. Then `done` pulses for one cycle with `err` at 0.
- R8: With `verify_en` high at `start`, acquisitions repeat until two consecutive acquisitions agree on both ports. The agreed value is then reported with `err` at 0. After a mismatch, the newer acquisition becomes the reference for the next comparison.
- R9: In verify mode, if the 15th consecutive mismatch (`MAX_RETRY`) occurs, the block stops polling. It pulses `done` with `err` at 1 and reports the latest acquisition, so 16 acquisitions run in total.
- R10: A `start` pulse that arrives while an acquisition sequence is in progress is ignored. It does not extend or repeat the sequence.
- R11: `buttons1`, `buttons2` and `err` change only in the cycle in which `done` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Pulse that begins an acquisition sequence when idle |
| verify_en | input | 1 | Selects the repeat-until-match mode, sampled at start |
| pad1_data | input | 2 | Port 1 data lines: bit 0 standard pad, bit 1 expansion pad |
| pad2_data | input | 2 | Port 2 data lines: bit 0 standard pad, bit 1 expansion pad |
| strobe_out | output | 1 | Latch strobe to both controllers |
| read_clk_out | output | 1 | Read clock to both controllers |
| buttons1 | output | 8 | Port 1 button byte, A in bit 7, Right in bit 0 |
| buttons2 | output | 8 | Port 2 button byte, A in bit 7, Right in bit 0 |
| done | output | 1 | One-cycle pulse when new results are presented |
| err | output | 1 | Set with done when the mismatch cap was reached |

## Verification
The bench builds the block with `STROBE_CYC` = 3 and `RCLK_HALF` = 1. This keeps each acquisition at about twenty cycles, so even the 16-acquisition sequence at the mismatch cap finishes quickly. `MAX_RETRY` keeps its default of 15, so the exact count of acquisitions at the cap is checked. A controller model in the bench can corrupt chosen acquisitions, either a single one or every one. This exercises a late agreement, an early agreement and the give-up path.

// File: rtl/pad_pkg.sv
package pad_pkg;

    localparam int BTN_W = 8;

    typedef enum logic [1:0] {
        SEQ_IDLE,
        SEQ_STROBE,
        SEQ_RLOW,
        SEQ_RHIGH
    } seq_state_e;

    typedef struct packed {
        logic [BTN_W-1:0] p1;
        logic [BTN_W-1:0] p2;
    } pad_pair_t;

    function automatic logic merge_lines(input logic [1:0] lines);
        return lines[0] | lines[1];
    endfunction

endpackage

// File: rtl/pad_seq.sv
module pad_seq
    import pad_pkg::*;
#(
    parameter int STROBE_CYC = 4,
    parameter int RCLK_HALF  = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic go,
    input  logic last_bit,
    output logic strobe_out,
    output logic read_clk_out,
    output logic load,
    output logic sample,
    output logic poll_done
);
    localparam int MAXC = (STROBE_CYC > RCLK_HALF) ? STROBE_CYC : RCLK_HALF;
    localparam int CW   = $clog2(MAXC + 1);

    seq_state_e    state;
    logic [CW-1:0] cnt;
    logic          fin;

    assign strobe_out   = (state == SEQ_STROBE);
    assign read_clk_out = (state == SEQ_RHIGH);
    assign load         = (state == SEQ_IDLE) && go;
    assign sample       = (state == SEQ_RLOW) && (cnt == '0);
    assign poll_done    = (state == SEQ_RHIGH) && (cnt == '0) && fin;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= SEQ_IDLE;
            cnt   <= '0;
            fin   <= 1'b0;
        end else begin
            case (state)
                SEQ_IDLE: begin
                    if (go) begin
                        state <= SEQ_STROBE;
                        cnt   <= CW'(STROBE_CYC - 1);
                        fin   <= 1'b0;
                    end
                end
                SEQ_STROBE: begin
                    if (cnt == '0) begin
                        state <= SEQ_RLOW;
                        cnt   <= CW'(RCLK_HALF - 1);
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                SEQ_RLOW: begin
                    if (cnt == '0) begin
                        state <= SEQ_RHIGH;
                        cnt   <= CW'(RCLK_HALF - 1);
                        if (last_bit) fin <= 1'b1;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                SEQ_RHIGH: begin
                    if (cnt == '0) begin
                        if (fin) begin
                            state <= SEQ_IDLE;
                        end else begin
                            state <= SEQ_RLOW;
                            cnt   <= CW'(RCLK_HALF - 1);
                        end
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                default: state <= SEQ_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/pad_capture.sv
module pad_capture
    import pad_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      load,
    input  logic      sample,
    input  logic [1:0] d1,
    input  logic [1:0] d2,
    output pad_pair_t res,
    output logic      last_bit
);
    logic [1:0]            din;
    logic [1:0][BTN_W-1:0] shv;

    assign din = {merge_lines(d2), merge_lines(d1)};

    for (genvar p = 0; p < 2; p++) begin : g_port
        localparam logic [BTN_W-1:0] PRE = (p == 1) ? BTN_W'(1) : '0;
        logic [BTN_W-1:0] sh;

        always_ff @(posedge clk) begin
            if (rst) begin
                sh <= '0;
            end else if (load) begin
                sh <= PRE;
            end else if (sample) begin
                sh <= {sh[BTN_W-2:0], din[p]};
            end
        end

        assign shv[p] = sh;
    end

    assign res.p1   = shv[0];
    assign res.p2   = shv[1];
    assign last_bit = shv[1][BTN_W-1];

endmodule

// File: rtl/pad_verify.sv
module pad_verify
    import pad_pkg::*;
#(
    parameter int MAX_RETRY = 15
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             verify_en,
    input  logic             poll_done,
    input  pad_pair_t        res,
    output logic             go,
    output logic [BTN_W-1:0] buttons1,
    output logic [BTN_W-1:0] buttons2,
    output logic             done,
    output logic             err
);
    localparam int RW = $clog2(MAX_RETRY + 1);

    logic          busy;
    logic          mode;
    logic          first;
    logic [RW-1:0] retry;
    pad_pair_t     ref_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy     <= 1'b0;
            mode     <= 1'b0;
            first    <= 1'b0;
            retry    <= '0;
            ref_q    <= '0;
            go       <= 1'b0;
            done     <= 1'b0;
            err      <= 1'b0;
            buttons1 <= '0;
            buttons2 <= '0;
        end else begin
            go   <= 1'b0;
            done <= 1'b0;
            if (!busy) begin
                if (start) begin
                    busy  <= 1'b1;
                    mode  <= verify_en;
                    first <= 1'b1;
                    retry <= '0;
                    go    <= 1'b1;
                end
            end else if (poll_done) begin
                if (!mode || (!first && res == ref_q)) begin
                    busy     <= 1'b0;
                    done     <= 1'b1;
                    err      <= 1'b0;
                    buttons1 <= res.p1;
                    buttons2 <= res.p2;
                end else if (first) begin
                    ref_q <= res;
                    first <= 1'b0;
                    go    <= 1'b1;
                end else if (retry == RW'(MAX_RETRY - 1)) begin
                    busy     <= 1'b0;
                    done     <= 1'b1;
                    err      <= 1'b1;
                    buttons1 <= res.p1;
                    buttons2 <= res.p2;
                end else begin
                    retry <= retry + 1'b1;
                    ref_q <= res;
                    go    <= 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/pad_poller.sv
module pad_poller
    import pad_pkg::*;
#(
    parameter int STROBE_CYC = 4,
    parameter int RCLK_HALF  = 3,
    parameter int MAX_RETRY  = 15
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             verify_en,
    input  logic [1:0]       pad1_data,
    input  logic [1:0]       pad2_data,
    output logic             strobe_out,
    output logic             read_clk_out,
    output logic [BTN_W-1:0] buttons1,
    output logic [BTN_W-1:0] buttons2,
    output logic             done,
    output logic             err
);
    logic      go;
    logic      load;
    logic      sample;
    logic      last_bit;
    logic      poll_done;
    pad_pair_t res;

    pad_seq #(
        .STROBE_CYC (STROBE_CYC),
        .RCLK_HALF  (RCLK_HALF)
    ) u_seq (
        .clk          (clk),
        .rst          (rst),
        .go           (go),
        .last_bit     (last_bit),
        .strobe_out   (strobe_out),
        .read_clk_out (read_clk_out),
        .load         (load),
        .sample       (sample),
        .poll_done    (poll_done)
    );

    pad_capture u_cap (
        .clk      (clk),
        .rst      (rst),
        .load     (load),
        .sample   (sample),
        .d1       (pad1_data),
        .d2       (pad2_data),
        .res      (res),
        .last_bit (last_bit)
    );

    pad_verify #(
        .MAX_RETRY (MAX_RETRY)
    ) u_ver (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .verify_en (verify_en),
        .poll_done (poll_done),
        .res       (res),
        .go        (go),
        .buttons1  (buttons1),
        .buttons2  (buttons2),
        .done      (done),
        .err       (err)
    );

endmodule

// File: rtl/pad_poller_chk.sv
module pad_poller_chk (
    input logic       clk,
    input logic       rst,
    input logic       strobe_out,
    input logic       read_clk_out,
    input logic [7:0] buttons1,
    input logic [7:0] buttons2,
    input logic       done,
    input logic       err
);
    AST_STROBE_RCLK_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(strobe_out && read_clk_out)); // R3

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R7

    AST_DONE_IDLE_BUS: assert property (@(posedge clk) disable iff (rst)
        done |-> (!strobe_out && !read_clk_out)); // R7

    AST_OUT_HOLD: assert property (@(posedge clk) disable iff (rst)
        !done |-> ($stable(buttons1) && $stable(buttons2) && $stable(err))); // R11

    AST_ERR_WITH_DONE: assert property (@(posedge clk) disable iff (rst)
        $rose(err) |-> done); // R9

endmodule

bind pad_poller pad_poller_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .strobe_out   (strobe_out),
    .read_clk_out (read_clk_out),
    .buttons1     (buttons1),
    .buttons2     (buttons2),
    .done         (done),
    .err          (err)
);

// File: tb/pad_poller_bench.sv
module pad_poller_bench;
    localparam int CLK_PERIOD = 10;
    localparam int STB        = 3;
    localparam int HALF       = 1;
    localparam int CAP        = 15;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       start = 1'b0;
    logic       verify_en = 1'b0;
    logic [1:0] pad1_data;
    logic [1:0] pad2_data;
    logic       strobe_out;
    logic       read_clk_out;
    logic [7:0] buttons1;
    logic [7:0] buttons2;
    logic       done;
    logic       err;

    int nchk = 0;
    int nerr = 0;

    pad_poller #(
        .STROBE_CYC (STB),
        .RCLK_HALF  (HALF),
        .MAX_RETRY  (CAP)
    ) u_pad_poller (
        .clk          (clk),
        .rst          (rst),
        .start        (start),
        .verify_en    (verify_en),
        .pad1_data    (pad1_data),
        .pad2_data    (pad2_data),
        .strobe_out   (strobe_out),
        .read_clk_out (read_clk_out),
        .buttons1     (buttons1),
        .buttons2     (buttons2),
        .done         (done),
        .err          (err)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // controller model
    logic [7:0] cfg_s1 = 0, cfg_e1 = 0, cfg_s2 = 0, cfg_e2 = 0;
    int         gmode = 0, gk = 0;
    logic       clr = 1'b0;
    logic [7:0] m_s1 = 0, m_e1 = 0, m_s2 = 0, m_e2 = 0;
    logic       stb_q = 1'b0, rck_q = 1'b0;
    int         poll_n = 0, rclk_n = 0, stb_cyc = 0;

    function automatic logic [7:0] gmask(int k);
        if (gmode == 1 && k == gk) return 8'h5A;
        if (gmode == 2) return k[7:0];
        return 8'h00;
    endfunction

    always @(posedge clk) begin
        stb_q <= strobe_out;
        rck_q <= read_clk_out;
        if (clr) begin
            poll_n  <= 0;
            rclk_n  <= 0;
            stb_cyc <= 0;
        end else begin
            if (strobe_out) stb_cyc <= stb_cyc + 1;
            if (strobe_out && !stb_q) begin
                poll_n <= poll_n + 1;
                m_s1   <= cfg_s1 ^ gmask(poll_n + 1);
                m_e1   <= cfg_e1;
                m_s2   <= cfg_s2 ^ gmask(poll_n + 1);
                m_e2   <= cfg_e2;
            end else if (read_clk_out && !rck_q) begin
                rclk_n <= rclk_n + 1;
                m_s1   <= {m_s1[6:0], 1'b1};
                m_e1   <= {m_e1[6:0], 1'b1};
                m_s2   <= {m_s2[6:0], 1'b1};
                m_e2   <= {m_e2[6:0], 1'b1};
            end
        end
    end

    assign pad1_data = {m_e1[7], m_s1[7]};
    assign pad2_data = {m_e2[7], m_s2[7]};

    function automatic logic [7:0] pv1(int k);
        return (cfg_s1 ^ gmask(k)) | cfg_e1;
    endfunction
    function automatic logic [7:0] pv2(int k);
        return (cfg_s2 ^ gmask(k)) | cfg_e2;
    endfunction

    task automatic chk(input logic ok, input string req, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic run_one(input logic [7:0] s1, input logic [7:0] e1,
                           input logic [7:0] s2, input logic [7:0] e2,
                           input logic vm, input int gm, input int k,
                           input logic busy_start);
        logic [7:0] x1, x2, n1, n2;
        logic       xe;
        int         np, mism, t, pn;
        @(negedge clk);
        cfg_s1 = s1; cfg_e1 = e1; cfg_s2 = s2; cfg_e2 = e2;
        gmode = gm; gk = k; clr = 1'b1;
        @(negedge clk);
        clr = 1'b0; verify_en = vm; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (busy_start) begin
            repeat (5) @(negedge clk);
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        // reference: R7 single, R8 repeat-until-match, R9 cap
        x1 = pv1(1); x2 = pv2(1); np = 1; xe = 1'b0;
        if (vm) begin
            mism = 0;
            for (int i = 0; i < 40; i++) begin
                np++;
                n1 = pv1(np); n2 = pv2(np);
                if (n1 == x1 && n2 == x2) break;
                mism++;
                x1 = n1; x2 = n2;
                if (mism == CAP) begin xe = 1'b1; break; end
            end
        end
        t = 0;
        while (!done && t < 5000) begin
            @(negedge clk);
            t++;
        end
        chk(done, "R7 done seen", done, 1);
        chk(buttons1 == x1, "R4 R5 R8 buttons1", buttons1, x1);
        chk(buttons2 == x2, "R6 R8 buttons2", buttons2, x2);
        chk(err == xe, "R9 err", err, xe);
        chk(poll_n == np, vm ? "R8 R9 R10 poll count" : "R7 R10 poll count", poll_n, np);
        chk(rclk_n == 8 * np, "R3 read clocks", rclk_n, 8 * np);
        chk(stb_cyc == STB * np, "R2 strobe cycles", stb_cyc, STB * np);
        pn = poll_n;
        @(negedge clk);
        chk(!done, "R7 done one cycle", done, 0);
        repeat (6) @(negedge clk);
        chk(poll_n == pn, "R10 no extra poll", poll_n, pn);
        chk(buttons1 == x1 && buttons2 == x2 && err == xe, "R11 outputs held",
            {buttons1, buttons2}, {x1, x2});
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        nerr++;
        $display("FAIL R7 watchdog expired actual=0 expected=1");
        $display("  CHECKS %0d ERRORS %0d", nchk, nerr);
        $finish;
    end

    initial begin
        void'($urandom(32'd7741));
        repeat (3) @(negedge clk);
        chk(buttons1 == 0 && buttons2 == 0 && !err && !done && !strobe_out && !read_clk_out,
            "R1 reset state", {buttons1, buttons2}, 0);
        rst = 1'b0;
        repeat (2) @(negedge clk);
        // R4 order: A only, then Right only
        run_one(8'h80, 8'h00, 8'h01, 8'h00, 1'b0, 0, 0, 1'b0);
        run_one(8'h01, 8'h00, 8'h80, 8'h00, 1'b0, 0, 0, 1'b0);
        // R5 OR of lines, R6 independent ports
        run_one(8'h0F, 8'hF0, 8'h00, 8'h81, 1'b0, 0, 0, 1'b0);
        run_one(8'h00, 8'h00, 8'hFF, 8'h00, 1'b0, 0, 0, 1'b0);
        // R8 verify clean, late glitch, early glitch
        run_one(8'hA5, 8'h00, 8'h3C, 8'h00, 1'b1, 0, 0, 1'b0);
        run_one(8'hA5, 8'h00, 8'h3C, 8'h00, 1'b1, 1, 2, 1'b0);
        run_one(8'h12, 8'h40, 8'hC3, 8'h00, 1'b1, 1, 1, 1'b0);
        // R9 cap reached, then a clean run clears err
        run_one(8'h66, 8'h00, 8'h99, 8'h00, 1'b1, 2, 0, 1'b0);
        run_one(8'h66, 8'h00, 8'h99, 8'h00, 1'b1, 0, 0, 1'b0);
        // R10 start while busy
        run_one(8'h5A, 8'h00, 8'hC0, 8'h00, 1'b0, 0, 0, 1'b1);
        run_one(8'h5A, 8'h00, 8'hC0, 8'h00, 1'b1, 1, 3, 1'b1);
        // random mix
        for (int i = 0; i < 30; i++) begin
            run_one(8'($urandom), 8'($urandom & 32'h11), 8'($urandom), 8'($urandom & 32'h22),
                    1'($urandom), int'($urandom % 3), 1 + int'($urandom % 3),
                    1'($urandom));
        end
        $display("  CHECKS %0d ERRORS %0d", nchk, nerr);
        $finish;
    end

endmodule